// File: doc/BRIEF.md
# Banked GPIO Pad Configuration Controller

This block holds the configuration of a row of general-purpose pads and presents it on a 32-bit register port. Each pad has five settings: a 2-bit function code, a 2-bit drive-strength code, a pull enable, an output value and an output enable. These are packed densely into banked registers, so a single register holds 16, 8 or 32 pads depending on the field. Every writable register can be reached at three addresses: one writes the value outright, one sets the written bits and one clears them. A sibling block can therefore change a single pad without a read-modify-write sequence. The current pad input levels are readable through a synchroniser.

A control register provides a soft-reset handshake. Setting the reset bit clears every pad setting. The block then raises a clock-gate bit by itself, and this bit freezes all gated state until software releases it. The release order is: clear the reset bit, then clear the gate bit.

Top module: `pinctrl_top`

## Requirements
- R1: After the synchronous active-low reset, every pad output vector is zero and the control register at 0x000 reads 0.
- R2: Address bits [11:8] select the register kind and bits [7:4] the register index. The kinds are 0 control, 1 function, 2 drive, 3 pull, 4 output data, 5 output enable and 6 input data. A write with bits [3:2]=0 replaces the register. A read returns the stored value in `bus_rdata` one clock after the read cycle, and `bus_rdata` holds its value between reads.
- R3: A write with bits [3:2]=1 ORs the data into the register, and bits [3:2]=2 clears the bits that are 1 in the data. All other bits are left unchanged. A write with bits [3:2]=3 is ignored, and a read at any alias returns the base value.
- R4: Function register k (0x100+0x10*k) holds pad p=16k+i at bits [2i+1:2i], and it drives `pad_func[2p+1:2p]`. Code 3 means GPIO.
- R5: Drive register k (0x200+0x10*k) holds pad p=8k+i at bits [4i+1:4i], and it drives `pad_drive[2p+1:2p]`. Codes 0/1/2 mean 4/8/12 mA, and bits [4i+3:4i+2] read as 0.
- R6: Pull (0x300), output-data (0x400) and output-enable (0x500) register k each hold pad 32k+i at bit i. They drive `pad_pull`, `pad_out` and `pad_oe`.
- R7: Input-data register k (0x600+0x10*k) shows `pad_in[32k+i]` at bit i after two synchroniser flops. Writes to it have no effect.
- R8: Writing 1 to control bit 31 (soft reset) clears every pad setting on the next clock. One clock after bit 31 reads 1, control bit 30 (clock gate) becomes 1 by itself.
- R9: While bit 31 or bit 30 is set, writes to non-control registers are ignored. While bit 30 is set, all pad settings and the input-data view hold their values.
- R10: Bit 30 stays set after bit 31 is cleared, and normal writes resume only once bit 30 has also been cleared.
- R11: Writes to a register index beyond the last one of a kind are ignored, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 96 | Pad input levels |
| pad_out | output | 96 | Pad output values |
| pad_oe | output | 96 | Pad output enables |
| pad_pull | output | 96 | Pad pull enables |
| pad_drive | output | 192 | Pad drive-strength codes, 2 bits per pad |
| pad_func | output | 192 | Pad function codes, 2 bits per pad |

## Verification
A register write reaches the pad vectors on the clock edge that ends the write cycle. A read value appears one edge after the read cycle. A pad input change needs two edges through the synchroniser before a read can capture it, so the bench waits two cycles before issuing the read. After a soft-reset write, the reset bit is visible one edge later, and the cleared pads and the raised gate bit one edge after that. The bench drives all stimulus on falling edges and samples on the falling edge that follows the due rising edge, so every comparison lands exactly in the cycle its result is due.

// File: rtl/pinctrl_pkg.sv
// Shared definitions for the pad configuration controller: address
// decode fields, alias operations and control-bit positions.
package pinctrl_pkg;

    localparam int REG_W = 32;

    // Alias operation carried in address bits [3:2].
    typedef enum logic [1:0] {
        OP_BASE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_RSVD = 2'd3
    } alias_op_e;

    // Register kind carried in address bits [11:8].
    typedef enum logic [3:0] {
        K_CTRL  = 4'h0,
        K_FUNC  = 4'h1,
        K_DRIVE = 4'h2,
        K_PULL  = 4'h3,
        K_DOUT  = 4'h4,
        K_DOE   = 4'h5,
        K_DIN   = 4'h6
    } reg_kind_e;

    localparam int CTRL_RST_BIT  = 31;
    localparam int CTRL_GATE_BIT = 30;

endpackage

// File: rtl/pinctrl_bank.sv
// Banked field storage. Holds NUM_FIELDS fields of FIELD_W bits, laid
// out REG_W/PITCH per register at a pitch of PITCH bits. It applies
// base/set/clear writes and returns a combinational read of one register.
// Assumes: wr_en is already qualified by the top (kind, reset, gate).
module pinctrl_bank
    import pinctrl_pkg::*;
#(
    parameter int NUM_FIELDS = 96,
    parameter int FIELD_W    = 2,
    parameter int PITCH      = 2,
    parameter int IDX_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_all,
    input  logic                          hold,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  alias_op_e                     wr_op,
    input  logic [REG_W-1:0]              wr_data,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [REG_W-1:0]              rd_data,
    output logic [NUM_FIELDS*FIELD_W-1:0] fields_o
);

    localparam int FPR = REG_W / PITCH;

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int RIDX = f / FPR;
        localparam int POS  = (f % FPR) * PITCH;
        logic [FIELD_W-1:0] cur;
        logic               hit;

        assign hit = wr_en && (wr_idx == IDX_W'(RIDX));

        // Field register: clear on reset or soft reset, update on an aliased write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur <= '0;
            end else if (clr_all) begin
                cur <= '0;
            end else if (!hold && hit) begin
                case (wr_op)
                    OP_BASE: cur <= wr_data[POS +: FIELD_W];
                    OP_SET:  cur <= cur | wr_data[POS +: FIELD_W];
                    OP_CLR:  cur <= cur & ~wr_data[POS +: FIELD_W];
                    default: cur <= cur;
                endcase
            end
        end

        assign fields_o[f*FIELD_W +: FIELD_W] = cur;
    end

    // Read assembly: place each field of the selected register at its position.
    always_comb begin
        rd_data = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (rd_idx == IDX_W'(f / FPR)) begin
                rd_data[(f % FPR) * PITCH +: FIELD_W] = fields_o[f*FIELD_W +: FIELD_W];
            end
        end
    end

endmodule

// File: rtl/pinctrl_sync.sv
// Two-flop synchroniser for the pad inputs. It clears on soft reset and
// freezes while the clock gate is set. Assumes pad inputs are asynchronous.
module pinctrl_sync #(
    parameter int WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    // Two-stage capture with clear and hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            meta <= '0;
            q    <= '0;
        end else if (!hold) begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/pinctrl_ctrl.sv
// Control register holding the soft-reset and clock-gate bits.
// While soft reset is set, the gate bit is forced on the next clock.
// Assumes wr_en is already decoded to the control address.
module pinctrl_ctrl
    import pinctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  alias_op_e        wr_op,
    input  logic [REG_W-1:0] wr_data,
    output logic             srst_o,
    output logic             gate_o
);

    logic [1:0] cur;
    logic [1:0] wbits;
    logic [1:0] nxt;
    logic       unused_wdata;

    assign unused_wdata = ^wr_data;
    assign cur   = {srst_o, gate_o};
    assign wbits = {wr_data[CTRL_RST_BIT], wr_data[CTRL_GATE_BIT]};

    // Apply the alias operation to the two live bits.
    always_comb begin
        case (wr_op)
            OP_BASE: nxt = wbits;
            OP_SET:  nxt = cur | wbits;
            OP_CLR:  nxt = cur & ~wbits;
            default: nxt = cur;
        endcase
    end

    // State update; an active soft reset wins over any write to the gate bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_o <= 1'b0;
            gate_o <= 1'b0;
        end else begin
            if (wr_en) begin
                srst_o <= nxt[1];
            end
            if (srst_o) begin
                gate_o <= 1'b1;
            end else if (wr_en) begin
                gate_o <= nxt[0];
            end
        end
    end

endmodule

// File: rtl/pinctrl_top.sv
// Pad configuration controller top. It decodes the register port into
// the five field banks and the control register, synchronises pad
// inputs and registers the read data. Assumes one access per cycle
// and a word-aligned address.
module pinctrl_top
    import pinctrl_pkg::*;
#(
    parameter int NUM_PINS = 96,
    parameter int ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_pull,
    output logic [2*NUM_PINS-1:0] pad_drive,
    output logic [2*NUM_PINS-1:0] pad_func
);

    localparam int IDX_W    = 4;
    localparam int BIT_REGS = (NUM_PINS + REG_W - 1) / REG_W;
    localparam int DIN_W    = BIT_REGS * REG_W;

    reg_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    alias_op_e         op;
    logic              wr_cyc;
    logic              wr_ok;
    logic              srst_q;
    logic              gate_q;
    logic [NUM_PINS-1:0] din_sync;
    logic [DIN_W-1:0]  din_wide;
    logic [31:0]       rd_func, rd_drv, rd_pull, rd_dout, rd_doe, rd_din;
    logic [31:0]       rd_mux;
    logic              unused_addr;

    assign kind        = reg_kind_e'(bus_addr[11:8]);
    assign idx         = bus_addr[7:4];
    assign op          = alias_op_e'(bus_addr[3:2]);
    assign unused_addr = ^bus_addr[1:0];
    assign wr_cyc      = bus_sel && bus_wr;
    assign wr_ok       = wr_cyc && !srst_q && !gate_q;

    pinctrl_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_cyc && (kind == K_CTRL) && (idx == '0)),
        .wr_op   (op),
        .wr_data (bus_wdata),
        .srst_o  (srst_q),
        .gate_o  (gate_q)
    );

    pinctrl_bank #(.NUM_FIELDS(NUM_PINS), .FIELD_W(2), .PITCH(2), .IDX_W(IDX_W)) u_func (
        .clk(clk), .rst_n(rst_n), .clr_all(srst_q), .hold(gate_q),
        .wr_en(wr_ok && (kind == K_FUNC)), .wr_idx(idx), .wr_op(op), .wr_data(bus_wdata),
        .rd_idx(idx), .rd_data(rd_func), .fields_o(pad_func)
    );

    pinctrl_bank #(.NUM_FIELDS(NUM_PINS), .FIELD_W(2), .PITCH(4), .IDX_W(IDX_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .clr_all(srst_q), .hold(gate_q),
        .wr_en(wr_ok && (kind == K_DRIVE)), .wr_idx(idx), .wr_op(op), .wr_data(bus_wdata),
        .rd_idx(idx), .rd_data(rd_drv), .fields_o(pad_drive)
    );

    pinctrl_bank #(.NUM_FIELDS(NUM_PINS), .FIELD_W(1), .PITCH(1), .IDX_W(IDX_W)) u_pull (
        .clk(clk), .rst_n(rst_n), .clr_all(srst_q), .hold(gate_q),
        .wr_en(wr_ok && (kind == K_PULL)), .wr_idx(idx), .wr_op(op), .wr_data(bus_wdata),
        .rd_idx(idx), .rd_data(rd_pull), .fields_o(pad_pull)
    );

    pinctrl_bank #(.NUM_FIELDS(NUM_PINS), .FIELD_W(1), .PITCH(1), .IDX_W(IDX_W)) u_dout (
        .clk(clk), .rst_n(rst_n), .clr_all(srst_q), .hold(gate_q),
        .wr_en(wr_ok && (kind == K_DOUT)), .wr_idx(idx), .wr_op(op), .wr_data(bus_wdata),
        .rd_idx(idx), .rd_data(rd_dout), .fields_o(pad_out)
    );

    pinctrl_bank #(.NUM_FIELDS(NUM_PINS), .FIELD_W(1), .PITCH(1), .IDX_W(IDX_W)) u_doe (
        .clk(clk), .rst_n(rst_n), .clr_all(srst_q), .hold(gate_q),
        .wr_en(wr_ok && (kind == K_DOE)), .wr_idx(idx), .wr_op(op), .wr_data(bus_wdata),
        .rd_idx(idx), .rd_data(rd_doe), .fields_o(pad_oe)
    );

    pinctrl_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .clr(srst_q), .hold(gate_q),
        .d(pad_in), .q(din_sync)
    );

    assign din_wide = DIN_W'(din_sync);

    // Input-data read: select one 32-bit slice of the synchronised inputs.
    always_comb begin
        rd_din = '0;
        for (int k = 0; k < BIT_REGS; k++) begin
            if (idx == IDX_W'(k)) begin
                rd_din = din_wide[k*REG_W +: REG_W];
            end
        end
    end

    // Read multiplexer across register kinds.
    always_comb begin
        case (kind)
            K_CTRL:  rd_mux = (idx == '0) ? {srst_q, gate_q, 30'b0} : 32'b0;
            K_FUNC:  rd_mux = rd_func;
            K_DRIVE: rd_mux = rd_drv;
            K_PULL:  rd_mux = rd_pull;
            K_DOUT:  rd_mux = rd_dout;
            K_DOE:   rd_mux = rd_doe;
            K_DIN:   rd_mux = rd_din;
            default: rd_mux = 32'b0;
        endcase
    end

    // Registered read data, updated only on a read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/pinctrl_top_chk.sv
// Property checker for pinctrl_top, attached with bind.
module pinctrl_top_chk #(
    parameter int NUM_PINS = 96
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  srst,
    input logic                  gate,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [31:0]           bus_rdata,
    input logic [NUM_PINS-1:0]   din,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_pull,
    input logic [2*NUM_PINS-1:0] pad_drive,
    input logic [2*NUM_PINS-1:0] pad_func
);

    // R8: soft reset clears every pad setting on the next clock.
    p_clear_on_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (pad_out == '0 && pad_oe == '0 && pad_pull == '0 &&
                  pad_drive == '0 && pad_func == '0));

    // R8: the gate bit follows an active soft reset by one clock.
    p_gate_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> gate);

    // R9: gated state holds while the gate is set.
    p_pads_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !srst) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pull) &&
                             $stable(pad_drive) && $stable(pad_func)));

    // R9: the input view freezes while gated.
    p_din_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !srst) |=> $stable(din));

    // R2: read data changes only after a read cycle.
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind pinctrl_top pinctrl_top_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .srst(srst_q), .gate(gate_q),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .din(din_sync),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
    .pad_drive(pad_drive), .pad_func(pad_func)
);

// File: tb/pinctrl_top_tb.sv
module pinctrl_top_tb;

    localparam int NP = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pull;
    logic [2*NP-1:0] pad_drive, pad_func;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] mdl [1:5][0:15];

    always #5 clk = ~clk;

    pinctrl_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .pad_drive(pad_drive), .pad_func(pad_func)
    );

    function automatic int reg_count(int kind);
        return (kind == 1) ? 6 : (kind == 2) ? 12 : 3;
    endfunction

    function automatic logic [31:0] kind_mask(int kind);
        return (kind == 2) ? 32'h3333_3333 : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [2*NP-1:0] exp_func();
        logic [2*NP-1:0] v;
        for (int p = 0; p < NP; p++) v[2*p +: 2] = mdl[1][p/16][2*(p%16) +: 2];
        return v;
    endfunction

    function automatic logic [2*NP-1:0] exp_drive();
        logic [2*NP-1:0] v;
        for (int p = 0; p < NP; p++) v[2*p +: 2] = mdl[2][p/8][4*(p%8) +: 2];
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_bits(int kind);
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p] = mdl[kind][p/32][p%32];
        return v;
    endfunction

    task automatic chk(input string req, input logic [2*NP-1:0] act, input logic [2*NP-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_pads(input string req);
        chk({req, " func"},  pad_func,  exp_func());
        chk({req, " drive"}, pad_drive, exp_drive());
        chk({req, " pull"},  {{NP{1'b0}}, pad_pull}, {{NP{1'b0}}, exp_bits(3)});
        chk({req, " dout"},  {{NP{1'b0}}, pad_out},  {{NP{1'b0}}, exp_bits(4)});
        chk({req, " doe"},   {{NP{1'b0}}, pad_oe},   {{NP{1'b0}}, exp_bits(5)});
    endtask

    task automatic model_clear();
        for (int k = 1; k <= 5; k++) for (int i = 0; i < 16; i++) mdl[k][i] = '0;
    endtask

    // Apply one write to the model and the DUT.
    task automatic do_write(input int kind, input int idx, input int op, input logic [31:0] d);
        logic [31:0] old;
        if (idx < reg_count(kind) && op != 3) begin
            old = mdl[kind][idx];
            case (op)
                0: mdl[kind][idx] = d & kind_mask(kind);
                1: mdl[kind][idx] = (old | d) & kind_mask(kind);
                default: mdl[kind][idx] = old & ~d & kind_mask(kind);
            endcase
        end
        wr({kind[3:0], idx[3:0], op[1:0], 2'b00}, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [NP-1:0] pin_v, held;
        void'($urandom(32'd4711));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_pads("R1");
        rd(12'h000, r); chk("R1 ctrl", {160'b0, r}, '0);

        // R4: directed GPIO code on pad 17 (reg 1, bits 3:2)
        do_write(1, 1, 0, 32'h0000_000C);
        chk("R4 pad17 func", {190'b0, pad_func[35:34]}, {190'b0, 2'd3});
        // R5: pad 9 at drive reg 1 bits 5:4, code 2; upper pitch bits read 0
        do_write(2, 1, 0, 32'hFFFF_FFEF);
        chk("R5 pad9 drive", {190'b0, pad_drive[19:18]}, {190'b0, 2'd2});
        rd(12'h210, r); chk("R5 readback", {160'b0, r}, {160'b0, 32'h3333_3323});
        // R6: pad 40 = output reg 1 bit 8
        do_write(4, 1, 1, 32'h0000_0100);
        chk("R6 pad40 out", {191'b0, pad_out[40]}, {191'b0, 1'b1});
        // R3: clear alias, and reserved alias ignored
        do_write(4, 1, 2, 32'h0000_0100);
        do_write(4, 1, 3, 32'hFFFF_FFFF);
        chk_pads("R3");
        // R11: out-of-range index ignored, reads 0
        do_write(1, 6, 0, 32'hFFFF_FFFF);
        rd(12'h160, r); chk("R11 read", {160'b0, r}, '0);
        chk_pads("R11");

        // R2 R3 R4 R5 R6: random mixed writes checked against the model
        for (int it = 0; it < 400; it++) begin
            int kind, idx, op, rop;
            kind = $urandom_range(1, 5);
            idx  = $urandom_range(0, reg_count(kind));
            op   = $urandom_range(0, 3);
            do_write(kind, idx, op, $urandom);
            rop = $urandom_range(0, 3);
            rd({kind[3:0], idx[3:0], rop[1:0], 2'b00}, r);
            chk("R2 R3 R11 readback", {160'b0, r},
                {160'b0, (idx < reg_count(kind)) ? mdl[kind][idx] : 32'b0});
            if (it % 20 == 0) chk_pads("R4 R5 R6");
        end
        chk_pads("R4 R5 R6 final");

        // R7: input view after two sync flops, writes ignored
        for (int j = 0; j < 4; j++) begin
            pin_v = {$urandom, $urandom, $urandom};
            @(negedge clk); pad_in = pin_v;
            repeat (2) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                rd(12'h600 | 12'(k << 4), r);
                chk("R7 din", {160'b0, r}, {160'b0, pin_v[32*k +: 32]});
            end
        end
        wr(12'h600, 32'h0);
        rd(12'h600, r); chk("R7 write ignored", {160'b0, r}, {160'b0, pin_v[31:0]});

        // R8: soft reset
        do_write(4, 0, 0, 32'hA5A5_A5A5);
        wr(12'h004, 32'h8000_0000);
        @(negedge clk);
        model_clear();
        chk_pads("R8 cleared");
        rd(12'h000, r); chk("R8 ctrl", {160'b0, r}, {160'b0, 32'hC000_0000});

        // R9: writes ignored while reset/gate set; input view held
        wr(12'h400, 32'hFFFF_FFFF);
        rd(12'h400, r); chk("R9 write in reset", {160'b0, r}, '0);
        wr(12'h008, 32'h8000_0000);
        rd(12'h000, r); chk("R10 gate stays", {160'b0, r}, {160'b0, 32'h4000_0000});
        wr(12'h500, 32'hFFFF_FFFF);
        rd(12'h500, r); chk("R9 write in gate", {160'b0, r}, '0);
        held = '0;
        @(negedge clk); pad_in = ~pin_v;
        repeat (3) @(negedge clk);
        rd(12'h600, r); chk("R9 din held", {160'b0, r}, {160'b0, held[31:0]});
        chk_pads("R9 pads held");

        // R10: release gate, writes resume
        wr(12'h008, 32'h4000_0000);
        rd(12'h000, r); chk("R10 ctrl", {160'b0, r}, '0);
        do_write(5, 2, 0, 32'h1234_5678);
        rd(12'h520, r); chk("R10 resume", {160'b0, r}, {160'b0, 32'h1234_5678});
        chk_pads("R10");
        repeat (2) @(negedge clk);
        rd(12'h620, r); chk("R10 din resumes", {160'b0, r}, {160'b0, ~pin_v[95:64]});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule